// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Flag Mode and Threshold Flags

This block is a synchronous FIFO on one clock. It has a write port, a read port and four status outputs. A mode input is captured while reset is held, and that captured mode decides what the two main status outputs mean.

- **Standard mode.** The read-side flag reports that the FIFO is empty and the write-side flag reports that it is full. A read request moves the oldest word into the output register.
- **Look-ahead mode.** The oldest word is moved into the output register without any read request. The read-side flag then means "a valid word is waiting at the output". The write-side flag means "room exists for another write". A read request consumes the waiting word.

Two active-low threshold flags give early warning before the FIFO runs dry or fills up:

- The low-water flag compares the stored word count against one offset.
- The high-water flag compares the number of free locations against a second offset.

Both offsets start from parameter defaults after reset. A neighbouring offset-programming block may replace them at any time through a one-cycle load strobe.

The read data leaves through an output enable that is registered on the clock. While that enable is low the data bus is forced to zero, standing in for a high-impedance bus.

Top module: `thresh_fifo`

## Requirements
- R1: While `rst_n` is low at a rising edge, the FIFO is emptied and the output enable is cleared. After such an edge the outputs are: `rd_flag`=1 and `wr_flag`=0 in standard mode; `rd_flag`=0 and `wr_flag`=1 in look-ahead mode; `almost_empty_n`=0 and `almost_full_n`=1 with the default offsets; `rd_data_en`=0; `rd_data`=0.
- R2: `fwft_sel` is sampled only at rising edges where `rst_n` is low (1 selects look-ahead, 0 selects standard). Changes to it while reset is released have no effect on behaviour.
- R3: In standard mode `rd_flag` is 1 exactly when no words are stored, and `wr_flag` is 1 exactly when DEPTH words are stored.
- R4: In standard mode, a rising edge with `rd_en`=1 and at least one stored word loads the oldest word into the output register. Words leave in write order.
- R5: In look-ahead mode, a word written into an empty FIFO is loaded into the output register by the following rising edge without any read request. `rd_flag` rises at that same edge.
- R6: In look-ahead mode, a rising edge with `rd_en`=1 and `rd_flag`=1 consumes the waiting word. At the same edge the next stored word, if any, is loaded. Otherwise `rd_flag` falls.
- R7: In look-ahead mode `wr_flag` is 1 exactly when the total count is below DEPTH. The total count includes the word held in the output register.
- R8: A write while the FIFO holds DEPTH words is dropped. A read while `rd_flag` shows no data (standard: empty; look-ahead: not ready) is ignored and leaves the output register unchanged.
- R9: `almost_empty_n` is 0 when the total count is below the low-water offset, and 1 when it is at or above it.
- R10: `almost_full_n` is 1 when the free locations (DEPTH minus total count) exceed the high-water offset, and 0 when they are at or below it.
- R11: After reset the offsets equal the parameters AE_DEFAULT and AF_DEFAULT. A rising edge with `ofs_load`=1 copies `ae_ofs` and `af_ofs`, and the flags use the new values from the next cycle on.
- R12: `rd_data_en` equals `rd_cs` sampled at the previous rising edge. `rd_data` shows the output register while `rd_data_en` is 1 and reads 0 otherwise.
- R13: A simultaneous accepted write and accepted read leave the count unchanged, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also captures the mode |
| fwft_sel | input | 1 | Mode choice captured during reset: 1 look-ahead, 0 standard |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request |
| rd_cs | input | 1 | Read chip select, registered into the output enable |
| ofs_load | input | 1 | Load strobe for both threshold offsets |
| ae_ofs | input | CW | New low-water offset |
| af_ofs | input | CW | New high-water offset |
| rd_data | output | DW | Output register, gated to zero while disabled |
| rd_data_en | output | 1 | Registered output enable |
| rd_flag | output | 1 | Empty (standard) or output-ready (look-ahead) |
| wr_flag | output | 1 | Full (standard) or input-ready (look-ahead) |
| almost_empty_n | output | 1 | Active-low low-water flag |
| almost_full_n | output | 1 | Active-low high-water flag |

## Verification
The bench builds the FIFO with an eight-deep, eight-bit memory and both default offsets at 2. This puts the full boundary, the wrap of both pointers and both threshold crossings only a handful of writes apart. With those values every flag edge is crossed many times during the mixed-traffic phases of each mode. Reprogramming the offsets to 5 and 1 moves the threshold crossings to different counts, which separates the stored offsets from the parameter defaults.

// File: rtl/thresh_fifo_pkg.sv
package thresh_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

endpackage

// File: rtl/thresh_fifo_store.sv
module thresh_fifo_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/thresh_fifo_ctrl.sv
module thresh_fifo_ctrl
    import thresh_fifo_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rd_cs,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic [DW-1:0] dout,
    output logic          oe,
    output logic          fwft,
    output logic          out_valid,
    output logic [CW-1:0] mem_cnt,
    output logic [CW-1:0] total_cnt
);

    localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

    typedef struct packed {
        fifo_mode_e    mode;
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] mcnt;
        logic          ov;
        logic [DW-1:0] dout;
        logic          oe;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic [CW-1:0] total_d;
    logic wacc_d, take_d, pop_d;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        if (POW2) begin
            return p + AW'(1);
        end
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        total_d = s_q.mcnt + CW'(s_q.mode == MODE_FWFT && s_q.ov);
        wacc_d  = wr_en && (total_d < CW'(DEPTH));
        pop_d   = rd_en && s_q.ov;
        if (s_q.mode == MODE_FWFT) begin
            take_d = (!s_q.ov || pop_d) && (s_q.mcnt != '0);
        end else begin
            take_d = rd_en && (s_q.mcnt != '0);
        end
        if (take_d) begin
            s_d.rptr = ptr_inc(s_q.rptr);
            s_d.dout = mem_rdata;
        end
        if (s_q.mode == MODE_FWFT) begin
            if (take_d) begin
                s_d.ov = 1'b1;
            end else if (pop_d) begin
                s_d.ov = 1'b0;
            end
        end
        if (wacc_d) begin
            s_d.wptr = ptr_inc(s_q.wptr);
        end
        s_d.mcnt = s_q.mcnt + CW'(wacc_d) - CW'(take_d);
        s_d.oe   = rd_cs;
        if (!rst_n) begin
            s_d      = '0;
            s_d.mode = fwft_sel ? MODE_FWFT : MODE_STD;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign mem_we    = wacc_d;
    assign mem_waddr = s_q.wptr;
    assign mem_raddr = s_q.rptr;
    assign dout      = s_q.dout;
    assign oe        = s_q.oe;
    assign fwft      = (s_q.mode == MODE_FWFT);
    assign out_valid = s_q.ov;
    assign mem_cnt   = s_q.mcnt;
    assign total_cnt = total_d;

    // R2: the captured mode never moves while reset is released
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(s_q.mode));

    // R8: stored count never exceeds the capacity
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mcnt <= CW'(DEPTH));

    // R8: a write at full capacity leaves the write pointer where it was
    a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && total_cnt == CW'(DEPTH)) |=> $stable(s_q.wptr));

    // R8: a standard-mode read when empty leaves the output register unchanged
    a_r8_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && rd_en && mem_cnt == '0) |=> $stable(s_q.dout) && $stable(s_q.rptr));

    // R5: a stored word behind an idle output stage is pulled forward at the next edge
    a_r5_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && !out_valid && mem_cnt != '0) |=> out_valid);

    // R13: standard mode, neither empty nor full, read and write together keep the count
    a_r13_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && wr_en && rd_en && mem_cnt != '0 && mem_cnt != CW'(DEPTH))
        |=> $stable(s_q.mcnt));

endmodule

// File: rtl/thresh_fifo_flags.sv
module thresh_fifo_flags #(
    parameter int DEPTH      = 16,
    parameter int AE_DEFAULT = 2,
    parameter int AF_DEFAULT = 2,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ofs_load,
    input  logic [CW-1:0] ae_ofs_in,
    input  logic [CW-1:0] af_ofs_in,
    input  logic          fwft,
    input  logic          out_valid,
    input  logic [CW-1:0] mem_cnt,
    input  logic [CW-1:0] total_cnt,
    output logic          rd_flag,
    output logic          wr_flag,
    output logic          ae_n,
    output logic          af_n
);

    typedef struct packed {
        logic [CW-1:0] ae_ofs;
        logic [CW-1:0] af_ofs;
    } ofs_st_t;

    ofs_st_t o_d, o_q;
    logic [CW-1:0] free_cnt;

    always_comb begin
        o_d = o_q;
        if (ofs_load) begin
            o_d.ae_ofs = ae_ofs_in;
            o_d.af_ofs = af_ofs_in;
        end
        if (!rst_n) begin
            o_d.ae_ofs = CW'(AE_DEFAULT);
            o_d.af_ofs = CW'(AF_DEFAULT);
        end
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    always_comb begin
        free_cnt = CW'(DEPTH) - total_cnt;
        if (fwft) begin
            rd_flag = out_valid;
            wr_flag = total_cnt < CW'(DEPTH);
        end else begin
            rd_flag = (mem_cnt == '0);
            wr_flag = (mem_cnt == CW'(DEPTH));
        end
        ae_n = (total_cnt >= o_q.ae_ofs);
        af_n = (free_cnt > o_q.af_ofs);
    end

    // R11: a load strobe lands both offsets in the following cycle
    a_r11_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_load |=> (o_q.ae_ofs == $past(ae_ofs_in)) && (o_q.af_ofs == $past(af_ofs_in)));

    // R11: without a strobe the offsets hold
    a_r11_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_load |=> $stable(o_q));

endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo #(
    parameter int DW         = 32,
    parameter int DEPTH      = 16,
    parameter int AE_DEFAULT = 2,
    parameter int AF_DEFAULT = 2,
    localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rd_cs,
    input  logic          ofs_load,
    input  logic [CW-1:0] ae_ofs,
    input  logic [CW-1:0] af_ofs,
    output logic [DW-1:0] rd_data,
    output logic          rd_data_en,
    output logic          rd_flag,
    output logic          wr_flag,
    output logic          almost_empty_n,
    output logic          almost_full_n
);

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata, dout;
    logic          fwft, out_valid;
    logic [CW-1:0] mem_cnt, total_cnt;

    thresh_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    thresh_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwft_sel  (fwft_sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rd_cs     (rd_cs),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .dout      (dout),
        .oe        (rd_data_en),
        .fwft      (fwft),
        .out_valid (out_valid),
        .mem_cnt   (mem_cnt),
        .total_cnt (total_cnt)
    );

    thresh_fifo_flags #(
        .DEPTH      (DEPTH),
        .AE_DEFAULT (AE_DEFAULT),
        .AF_DEFAULT (AF_DEFAULT)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ofs_load  (ofs_load),
        .ae_ofs_in (ae_ofs),
        .af_ofs_in (af_ofs),
        .fwft      (fwft),
        .out_valid (out_valid),
        .mem_cnt   (mem_cnt),
        .total_cnt (total_cnt),
        .rd_flag   (rd_flag),
        .wr_flag   (wr_flag),
        .ae_n      (almost_empty_n),
        .af_n      (almost_full_n)
    );

    assign rd_data = rd_data_en ? dout : '0;

    // R12: output enable is the chip select delayed by one edge
    a_r12_enable_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_data_en == $past(rd_cs));

endmodule

// File: tb/thresh_fifo_bench.sv
module thresh_fifo_bench;

    localparam int DW = 8;
    localparam int DEPTH = 8;
    localparam int AE_DEF = 2;
    localparam int AF_DEF = 2;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwft_sel = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic rd_cs = 1'b0;
    logic ofs_load = 1'b0;
    logic [CW-1:0] ae_ofs = '0;
    logic [CW-1:0] af_ofs = '0;
    logic [DW-1:0] rd_data;
    logic rd_data_en, rd_flag, wr_flag, almost_empty_n, almost_full_n;

    always #2.5 clk = ~clk;

    thresh_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_DEFAULT(AE_DEF), .AF_DEFAULT(AF_DEF)) u_thresh_fifo (
        .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_cs(rd_cs), .ofs_load(ofs_load), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .rd_data(rd_data), .rd_data_en(rd_data_en), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string phase = "R1 reset";

    // behavioural reference state
    int m_mode;
    int m_q[$];
    int m_ov, m_dout, m_oe, m_aeo, m_afo;
    bit started = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = fwft_sel ? 1 : 0;
            m_q.delete();
            m_ov = 0; m_dout = 0; m_oe = 0;
            m_aeo = AE_DEF; m_afo = AF_DEF;
        end else begin
            int tot;
            bit wacc, pop, take;
            tot  = m_q.size() + ((m_mode == 1) ? m_ov : 0);
            wacc = wr_en && (tot < DEPTH);
            if (m_mode == 1) begin
                pop  = rd_en && (m_ov == 1);
                take = ((m_ov == 0) || pop) && (m_q.size() > 0);
                if (take) begin m_dout = m_q.pop_front(); m_ov = 1; end
                else if (pop) m_ov = 0;
            end else begin
                take = rd_en && (m_q.size() > 0);
                if (take) m_dout = m_q.pop_front();
            end
            if (wacc) m_q.push_back(int'(wr_data));
            m_oe = rd_cs ? 1 : 0;
            if (ofs_load) begin m_aeo = int'(ae_ofs); m_afo = int'(af_ofs); end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            int tot, e_rd, e_wr, e_ae, e_af, e_data;
            tot = m_q.size() + ((m_mode == 1) ? m_ov : 0);
            if (m_mode == 1) begin
                e_rd = m_ov;
                e_wr = (tot < DEPTH) ? 1 : 0;
                chk(rd_flag == e_rd[0], "R5/R6 rd_flag", rd_flag, e_rd);
                chk(wr_flag == e_wr[0], "R7 wr_flag", wr_flag, e_wr);
            end else begin
                e_rd = (m_q.size() == 0) ? 1 : 0;
                e_wr = (m_q.size() == DEPTH) ? 1 : 0;
                chk(rd_flag == e_rd[0], "R3 rd_flag", rd_flag, e_rd);
                chk(wr_flag == e_wr[0], "R3 wr_flag", wr_flag, e_wr);
            end
            e_ae = (tot >= m_aeo) ? 1 : 0;
            e_af = ((DEPTH - tot) > m_afo) ? 1 : 0;
            e_data = (m_oe == 1) ? m_dout : 0;
            chk(almost_empty_n == e_ae[0], "R9 almost_empty_n", almost_empty_n, e_ae);
            chk(almost_full_n == e_af[0], "R10 almost_full_n", almost_full_n, e_af);
            chk(rd_data_en == m_oe[0], "R12 rd_data_en", rd_data_en, m_oe);
            chk(int'(rd_data) == e_data, "R4/R6/R8 rd_data", rd_data, e_data);
        end
    end

    task automatic step(input bit w, input bit r, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
    endtask

    task automatic rnd_traffic(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            wr_en = lfsr[0] | lfsr[3];
            rd_en = lfsr[1] | lfsr[5];
            rd_cs = lfsr[7] | lfsr[2];
            wr_data = lfsr[15:8];
        end
    endtask

    task automatic do_reset(input bit sel);
        @(negedge clk);
        rst_n = 1'b0; fwft_sel = sel; wr_en = 0; rd_en = 0; rd_cs = 0;
        repeat (3) @(negedge clk);
        phase = "R1 reset state";
        if (sel) begin
            chk(rd_flag == 1'b0, "R1 rd_flag", rd_flag, 0);
            chk(wr_flag == 1'b1, "R1 wr_flag", wr_flag, 1);
        end else begin
            chk(rd_flag == 1'b1, "R1 rd_flag", rd_flag, 1);
            chk(wr_flag == 1'b0, "R1 wr_flag", wr_flag, 0);
        end
        chk(almost_empty_n == 1'b0, "R1 almost_empty_n", almost_empty_n, 0);
        chk(almost_full_n == 1'b1, "R1 almost_full_n", almost_full_n, 1);
        chk(rd_data_en == 1'b0, "R1 rd_data_en", rd_data_en, 0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        fwft_sel = ~sel;   // R2: ignored once reset is released
        rd_cs = 1'b1;
    endtask

    initial begin
        do_reset(1'b0);
        phase = "R2 R3 R8 standard fill";
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, DW'(i + 1));
        phase = "R4 R8 standard drain";
        for (int i = 0; i < DEPTH + 2; i++) step(0, 1, '0);
        phase = "R13 R12 standard mixed";
        rnd_traffic(300);
        phase = "R11 offset reprogram";
        step(0, 1, '0); rd_cs = 1;
        @(negedge clk); ofs_load = 1; ae_ofs = CW'(5); af_ofs = CW'(1);
        @(negedge clk); ofs_load = 0; ae_ofs = '0; af_ofs = '0;
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, DW'(8'h40 + i));
        for (int i = 0; i < DEPTH + 1; i++) step(0, 1, '0);

        do_reset(1'b1);
        phase = "R5 look-ahead first word";
        step(1, 0, 8'hA5);
        for (int i = 0; i < 3; i++) step(0, 0, '0);
        phase = "R6 R8 look-ahead read";
        step(1, 0, 8'h3C);
        for (int i = 0; i < 3; i++) step(0, 1, '0);
        phase = "R7 R8 look-ahead fill";
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, DW'(8'h80 + i));
        phase = "R6 R8 look-ahead drain";
        for (int i = 0; i < DEPTH + 3; i++) step(0, 1, '0);
        phase = "R13 R12 look-ahead mixed";
        rnd_traffic(300);
        phase = "R11 look-ahead offsets";
        @(negedge clk); ofs_load = 1; ae_ofs = CW'(3); af_ofs = CW'(4); wr_en = 0; rd_en = 0;
        @(negedge clk); ofs_load = 0;
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, DW'(i));
        for (int i = 0; i < DEPTH + 1; i++) step(0, 1, '0);
        step(0, 0, '0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule